// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel whose work is described by a chain of descriptors held in ordinary memory. Software writes the address of the first descriptor, then sets the run bit in the control/status register. The channel reads the eight-word descriptor, then copies the requested number of bytes one word at a time. Each word is read from the source address and then written to the destination address. Either address may advance after each word or stay fixed, which suits a peripheral data port. Each read or each write can be held back until a chosen peripheral request line is high.

When a descriptor finishes, the channel can raise its interrupt. It then loads the descriptor named by the link word. A zero link ends the chain. A link back to an earlier descriptor makes the chain repeat without end. Software can control the channel in four ways:
- Clearing the run bit pauses it at a clean point.
- Writing the skip bit together with the run bit ends the current descriptor early.
- Writing 1 to the interrupt flag clears it.
- Writing the wipe bit returns the channel to its reset state.

Top module: `cb_dma_chan`

## Requirements
- R1: After reset, every readable register reads 0, no memory request is issued and irq_o is low.
- R2: Start (idle channel, descriptor address at offset 0x04 nonzero, status write with bit 0 = 1):
  - The channel makes eight sequential word reads from the descriptor address.
  - It keeps word 0 as the info word, word 1 as the source, word 2 as the destination, word 3 as the byte count and word 5 as the link.
  - The current source reads back at 0x0C, the destination at 0x10, the remaining count at 0x14 and the link at 0x1C.
- R3: Data movement:
  - The channel moves ceil(count/4) words, each as a read of the source followed by a write of that value to the destination.
  - The source advances by 4 per word when info bit 8 is set. The destination advances by 4 per word when info bit 4 is set.
  - The address registers show this progress live.
  - A memory request holds its address until it is acknowledged.
- R4: A descriptor that completes with info bit 0 set raises status bit 2 and irq_o.
- R5: A status write with bit 2 = 1 clears the interrupt flag. If bit 0 is also 1 in that write, the transfer continues to completion.
- R6: At descriptor end, a nonzero link loads the next descriptor. A zero link clears status bit 0. A circular chain keeps running.
- R7: Pacing:
  - Info bit 10 paces source reads and info bit 6 paces destination writes.
  - Info bits 20:16 select the request line dreq_i that paces them.
  - While a paced access waits for its line, status bit 5 is 1 and no progress is made.
- R8: A status write with bit 0 = 0 pauses the channel:
  - Any access in flight completes, then no new request is issued.
  - Status bit 4 reads 1 while paused with work loaded.
  - Writing bit 0 = 1 resumes the transfer.
- R9: A status write with bits 30 and 0 set ends the current descriptor at the next access boundary without raising the interrupt, then follows the link. If the link at 0x1C was first written to 0, the channel goes idle.
- R10: A memory response with the error signal set raises status bit 8 and stops the channel.
- R11: A status write with bit 31 set clears the run bit, the interrupt flag, the error flag, the descriptor address and all working registers in one cycle, and withdraws any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access complete |
| mem_err_i | input | 1 | Access failed, valid with mem_ack_i |
| dreq_i | input | N_DREQ | Peripheral request lines |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the channel with its defaults: 32 request lines and an 8-bit register offset. This makes lines 3 and 7 selectable for the paced stalls and puts every register offset in the map within reach. A memory model with a random latency of 0 to 2 cycles stresses the hold-until-acknowledge rule and the pause point. Address bits above 13 trigger the error response. Random copies with mixed increment flags and ragged byte counts are checked against a bench-side copy model.

// File: rtl/cb_dma_pkg.sv
package cb_dma_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned CB_WORDS = 8;
  localparam int unsigned IDX_W    = $clog2(CB_WORDS);
  localparam int unsigned SEL_W    = 5;

  localparam logic [7:0] OFS_CS  = 8'h00;
  localparam logic [7:0] OFS_CBA = 8'h04;
  localparam logic [7:0] OFS_SRC = 8'h0C;
  localparam logic [7:0] OFS_DST = 8'h10;
  localparam logic [7:0] OFS_LEN = 8'h14;
  localparam logic [7:0] OFS_NXT = 8'h1C;

  localparam int unsigned CS_RUN   = 0;
  localparam int unsigned CS_FLAG  = 2;
  localparam int unsigned CS_PAUSE = 4;
  localparam int unsigned CS_HELD  = 5;
  localparam int unsigned CS_ERR   = 8;
  localparam int unsigned CS_SKIP  = 30;
  localparam int unsigned CS_WIPE  = 31;

  localparam int unsigned TI_IRQ_EN = 0;
  localparam int unsigned TI_D_INC  = 4;
  localparam int unsigned TI_D_PACE = 6;
  localparam int unsigned TI_S_INC  = 8;
  localparam int unsigned TI_S_PACE = 10;
  localparam int unsigned TI_SEL_LO = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RD, ST_WR, ST_DONE
  } dma_st_e;
endpackage

// File: rtl/cb_dma_dreq_sel.sv
module cb_dma_dreq_sel
  import cb_dma_pkg::*;
#(
  parameter int unsigned N_DREQ = 32
) (
  input  logic [N_DREQ-1:0] dreq_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              need_i,
  output logic              ok_o
);
  logic hit;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_DREQ; i++)
      if (sel_i == SEL_W'(i)) hit = dreq_i[i];
  end
  assign ok_o = !need_i || hit;
endmodule

// File: rtl/cb_dma_rdmux.sv
module cb_dma_rdmux
  import cb_dma_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     cs_i,
  input  logic [DW-1:0]     cba_i,
  input  logic [DW-1:0]     src_i,
  input  logic [DW-1:0]     dst_i,
  input  logic [DW-1:0]     len_i,
  input  logic [DW-1:0]     nxt_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    unique case (addr_i)
      REG_AW'(OFS_CS):  rdata_o = cs_i;
      REG_AW'(OFS_CBA): rdata_o = cba_i;
      REG_AW'(OFS_SRC): rdata_o = src_i;
      REG_AW'(OFS_DST): rdata_o = dst_i;
      REG_AW'(OFS_LEN): rdata_o = len_i;
      REG_AW'(OFS_NXT): rdata_o = nxt_i;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cb_dma_ctrl.sv
module cb_dma_ctrl
  import cb_dma_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic              pace_ok_i,
  output logic              pace_need_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DW-1:0]     cs_o,
  output logic [DW-1:0]     cba_o,
  output logic [DW-1:0]     src_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     len_o,
  output logic [DW-1:0]     nxt_o,
  output logic              run_o,
  output logic              done_o,
  output logic              irq_o
);
  dma_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             run_q, flag_q, err_q, skip_q, req_q;
  logic [DW-1:0]    cba_q, info_q, src_q, dst_q, len_q, nxt_q, buf_q;

  logic cs_wr, wipe, ack, data_st, issue, held, paused;
  logic [DW-1:0] len_nxt;

  assign cs_wr   = reg_we_i && reg_addr_i == REG_AW'(OFS_CS);
  assign wipe    = cs_wr && reg_wdata_i[CS_WIPE];
  assign ack     = req_q && mem_ack_i;
  assign data_st = (st_q == ST_RD) || (st_q == ST_WR);
  assign pace_need_o = (st_q == ST_RD && info_q[TI_S_PACE]) ||
                       (st_q == ST_WR && info_q[TI_D_PACE]);
  assign sel_o   = info_q[TI_SEL_LO +: SEL_W];
  // new access only at a boundary, while running, paced line ready
  assign issue   = run_q && !req_q && !skip_q && pace_ok_i;
  assign held    = run_q && !req_q && !skip_q && data_st && !pace_ok_i;
  assign paused  = !run_q && st_q != ST_IDLE && !req_q;
  assign len_nxt = (len_q <= DW'(4)) ? '0 : len_q - DW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0;
      run_q <= 1'b0; flag_q <= 1'b0; err_q <= 1'b0; skip_q <= 1'b0; req_q <= 1'b0;
      cba_q <= '0; info_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; nxt_q <= '0; buf_q <= '0;
    end else if (wipe) begin
      st_q <= ST_IDLE; idx_q <= '0;
      run_q <= 1'b0; flag_q <= 1'b0; err_q <= 1'b0; skip_q <= 1'b0; req_q <= 1'b0;
      cba_q <= '0; info_q <= '0; src_q <= '0; dst_q <= '0;
      len_q <= '0; nxt_q <= '0; buf_q <= '0;
    end else begin
      if (cs_wr) begin
        run_q <= reg_wdata_i[CS_RUN];
        if (reg_wdata_i[CS_FLAG]) flag_q <= 1'b0;
        if (reg_wdata_i[CS_SKIP] && reg_wdata_i[CS_RUN] && st_q != ST_IDLE) skip_q <= 1'b1;
      end
      if (reg_we_i && reg_addr_i == REG_AW'(OFS_CBA) && st_q == ST_IDLE) cba_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == REG_AW'(OFS_NXT)) nxt_q <= reg_wdata_i;

      unique case (st_q)
        ST_IDLE: if (cs_wr && reg_wdata_i[CS_RUN]) begin
          if (cba_q != '0) begin st_q <= ST_FETCH; idx_q <= '0; end
          else run_q <= 1'b0;
        end
        ST_FETCH: begin
          if (run_q && !req_q) req_q <= 1'b1;
          if (ack) begin
            req_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
            unique case (idx_q)
              IDX_W'(0): info_q <= mem_rdata_i;
              IDX_W'(1): src_q  <= mem_rdata_i;
              IDX_W'(2): dst_q  <= mem_rdata_i;
              IDX_W'(3): len_q  <= mem_rdata_i;
              IDX_W'(5): nxt_q  <= mem_rdata_i;
              default: ;
            endcase
            if (idx_q == IDX_W'(CB_WORDS-1)) st_q <= (len_q == '0) ? ST_DONE : ST_RD;
          end
        end
        ST_RD: begin
          if (skip_q && !req_q) st_q <= ST_DONE;
          else if (issue) req_q <= 1'b1;
          if (ack) begin req_q <= 1'b0; buf_q <= mem_rdata_i; st_q <= ST_WR; end
        end
        ST_WR: begin
          if (skip_q && !req_q) st_q <= ST_DONE;
          else if (issue) req_q <= 1'b1;
          if (ack) begin
            req_q <= 1'b0;
            if (info_q[TI_S_INC]) src_q <= src_q + DW'(4);
            if (info_q[TI_D_INC]) dst_q <= dst_q + DW'(4);
            len_q <= len_nxt;
            st_q  <= (len_nxt == '0) ? ST_DONE : ST_RD;
          end
        end
        ST_DONE: begin
          if (info_q[TI_IRQ_EN] && !skip_q) flag_q <= 1'b1;
          skip_q <= 1'b0;
          if (nxt_q == '0) begin
            st_q <= ST_IDLE; run_q <= 1'b0; cba_q <= '0;
          end else begin
            st_q <= ST_FETCH; cba_q <= nxt_q; idx_q <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (ack && mem_err_i) begin
        err_q <= 1'b1; run_q <= 1'b0; skip_q <= 1'b0; req_q <= 1'b0; st_q <= ST_IDLE;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_FETCH: mem_addr_o = cba_q + DW'({idx_q, 2'b00});
      ST_WR:    mem_addr_o = dst_q;
      default:  mem_addr_o = src_q;
    endcase
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_wdata_o = buf_q;

  always_comb begin
    cs_o           = '0;
    cs_o[CS_RUN]   = run_q;
    cs_o[CS_FLAG]  = flag_q;
    cs_o[CS_PAUSE] = paused;
    cs_o[CS_HELD]  = held;
    cs_o[CS_ERR]   = err_q;
  end

  assign cba_o  = cba_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign len_o  = len_q;
  assign nxt_o  = nxt_q;
  assign run_o  = run_q;
  assign done_o = (st_q == ST_DONE);
  assign irq_o  = flag_q;
endmodule

// File: rtl/cb_dma_chan.sv
module cb_dma_chan
  import cb_dma_pkg::*;
#(
  parameter int unsigned N_DREQ = 32,
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [N_DREQ-1:0] dreq_i,
  output logic              irq_o
);
  logic             pace_ok, pace_need, run_act, blk_done;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    cs_w, cba_w, src_w, dst_w, len_w, nxt_w;

  cb_dma_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i, .mem_err_i,
    .pace_ok_i(pace_ok), .pace_need_o(pace_need), .sel_o(sel),
    .cs_o(cs_w), .cba_o(cba_w), .src_o(src_w), .dst_o(dst_w),
    .len_o(len_w), .nxt_o(nxt_w),
    .run_o(run_act), .done_o(blk_done), .irq_o
  );

  cb_dma_dreq_sel #(.N_DREQ(N_DREQ)) u_dreq (
    .dreq_i, .sel_i(sel), .need_i(pace_need), .ok_o(pace_ok)
  );

  cb_dma_rdmux #(.REG_AW(REG_AW)) u_rdmux (
    .addr_i(reg_addr_i), .cs_i(cs_w), .cba_i(cba_w), .src_i(src_w),
    .dst_i(dst_w), .len_i(len_w), .nxt_i(nxt_w), .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/cb_dma_chk.sv
module cb_dma_chk
  import cb_dma_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic              mem_req_o,
  input logic [DW-1:0]     mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic              irq_o,
  input logic              done_i,
  input logic              run_i
);
  logic cs_wr, wipe;
  assign cs_wr = reg_we_i && reg_addr_i == REG_AW'(OFS_CS);
  assign wipe  = cs_wr && reg_wdata_i[CS_WIPE];

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !wipe |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_IRQ_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i)); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_wr && reg_wdata_i[CS_FLAG] && !done_i |=> !irq_o); // R5
  AST_PAUSE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !mem_req_o |=> !mem_req_o); // R8
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i |=> !mem_req_o && !run_i); // R10
  AST_WIPE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe |=> !mem_req_o && !irq_o && !run_i); // R11
endmodule

bind cb_dma_chan cb_dma_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i), .irq_o(irq_o),
  .done_i(blk_done), .run_i(run_act)
);

// File: tb/cb_dma_chan_tb_top.sv
module cb_dma_chan_tb_top;
  localparam int N_DREQ = 32;
  localparam logic [31:0] I_IRQ = 32'h1, I_DINC = 32'h10, I_DPACE = 32'h40,
                          I_SINC = 32'h100, I_SPACE = 32'h400;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        we = 1'b0;
  logic [7:0]  raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mreq, mwe, mack = 1'b0, merr = 1'b0, irq;
  logic [31:0] maddr, mwdata, mrdata = '0;
  logic [N_DREQ-1:0] dreq = '0;
  logic [1:0]  lat = '0;

  logic [31:0] mem    [0:4095];
  logic [31:0] shadow [0:4095];
  int checks = 0, errors = 0;

  cb_dma_chan #(.N_DREQ(N_DREQ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .mem_ack_i(mack), .mem_err_i(merr), .dreq_i(dreq), .irq_o(irq)
  );

  // memory model: random latency, error above 16 KiB
  always @(posedge clk) begin
    if (mack) begin mack <= 1'b0; merr <= 1'b0; end
    else if (mreq) begin
      if (lat == 0) begin
        mack <= 1'b1;
        lat  <= 2'($urandom % 3);
        if (maddr[31:14] != 0) begin merr <= 1'b1; mrdata <= 32'hDEAD_BEEF; end
        else if (mwe) mem[maddr[13:2]] <= mwdata;
        else mrdata <= mem[maddr[13:2]];
      end else lat <= lat - 1'b1;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; raddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(string rq);
    logic [31:0] cs;
    for (int k = 0; k < 5000; k++) begin
      rd(8'h00, cs);
      if (!cs[0]) break;
    end
    chk(rq, {31'd0, cs[0]}, 32'd0);
  endtask

  task automatic put_cb(int base, logic [31:0] info, logic [31:0] s, logic [31:0] d,
                        logic [31:0] len, logic [31:0] nxt);
    mem[base/4+0] = info; mem[base/4+1] = s; mem[base/4+2] = d; mem[base/4+3] = len;
    mem[base/4+4] = 32'h0; mem[base/4+5] = nxt; mem[base/4+6] = 32'h0; mem[base/4+7] = 32'h0;
  endtask

  task automatic snap();
    for (int k = 0; k < 4096; k++) shadow[k] = mem[k];
  endtask

  function automatic int words_of(logic [31:0] len);
    return (int'(len) + 3) / 4;
  endfunction

  task automatic model_copy(logic [31:0] s, logic [31:0] d, logic [31:0] len, bit si, bit di);
    for (int k = 0; k < words_of(len); k++) begin
      shadow[d[13:2]] = shadow[s[13:2]];
      if (si) s += 4;
      if (di) d += 4;
    end
  endtask

  task automatic cmp(string rq, logic [31:0] d, int n);
    for (int k = 0; k < n; k++) chk(rq, mem[d[13:2] + k], shadow[d[13:2] + k]);
  endtask

  task automatic start(int cb);
    wr(8'h04, cb); wr(8'h00, 32'h1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, d1;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4096; k++) mem[k] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 cs", v, 0);
    rd(8'h04, v); chk("R1 cba", v, 0);
    rd(8'h0C, v); chk("R1 src", v, 0);
    chk("R1 req", {31'd0, mreq}, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 R3 R4 single block copy
    put_cb(32'h40, I_IRQ | I_SINC | I_DINC, 32'h1000, 32'h2000, 16, 0);
    snap(); model_copy(32'h1000, 32'h2000, 16, 1, 1);
    start(32'h40); wait_idle("R2 finish");
    cmp("R3 copy", 32'h2000, 4);
    rd(8'h0C, v); chk("R3 src end", v, 32'h1010);
    rd(8'h10, v); chk("R3 dst end", v, 32'h2010);
    rd(8'h00, v); chk("R4 flag", v & 32'h4, 32'h4);
    chk("R4 irq", {31'd0, irq}, 1);
    wr(8'h00, 32'h4);
    rd(8'h00, v); chk("R5 flag clr", v & 32'h4, 0);
    chk("R5 irq clr", {31'd0, irq}, 0);

    // R6 two-block chain, fixed destination in the first
    put_cb(32'h60, I_SINC, 32'h1040, 32'h2100, 12, 32'h80);
    put_cb(32'h80, I_SINC | I_DINC | I_IRQ, 32'h1080, 32'h2200, 8, 0);
    snap(); model_copy(32'h1040, 32'h2100, 12, 1, 0); model_copy(32'h1080, 32'h2200, 8, 1, 1);
    start(32'h60); wait_idle("R6 chain end");
    cmp("R3 fixed dst", 32'h2100, 1);
    cmp("R6 second block", 32'h2200, 2);
    rd(8'h10, v); chk("R6 dst end", v, 32'h2208);
    wr(8'h00, 32'h4);

    // R7 pacing on line 7, R2 working registers
    put_cb(32'hA0, I_SPACE | I_SINC | I_DINC | (32'd7 << 16), 32'h10C0, 32'h2300, 8, 0);
    snap(); model_copy(32'h10C0, 32'h2300, 8, 1, 1);
    start(32'hA0);
    repeat (80) @(negedge clk);
    rd(8'h00, v); chk("R7 held", v & 32'h21, 32'h21);
    rd(8'h10, v); chk("R7 no progress", v, 32'h2300);
    rd(8'h14, v); chk("R2 len latched", v, 8);
    rd(8'h0C, v); chk("R2 src latched", v, 32'h10C0);
    dreq[7] = 1'b1;
    wait_idle("R7 paced end");
    cmp("R7 paced copy", 32'h2300, 2);
    dreq = '0;

    // R8 pause and resume, R5 resume with flag clear
    put_cb(32'hC0, I_SINC | I_DINC, 32'h1000, 32'h2400, 64, 0);
    snap(); model_copy(32'h1000, 32'h2400, 64, 1, 1);
    start(32'hC0);
    repeat (40) @(negedge clk);
    wr(8'h00, 32'h0);
    repeat (10) @(negedge clk);
    rd(8'h00, v); chk("R8 paused", v & 32'h11, 32'h10);
    rd(8'h10, d1);
    repeat (30) @(negedge clk);
    rd(8'h10, v); chk("R8 stalled", v, d1);
    wr(8'h00, 32'h5);
    wait_idle("R5 runs on");
    cmp("R8 resumed copy", 32'h2400, 16);

    // R9 skip to next block
    put_cb(32'hE0, I_SPACE | I_SINC | I_DINC | I_IRQ | (32'd3 << 16), 32'h1000, 32'h2500, 16, 32'h100);
    put_cb(32'h100, I_SINC | I_DINC, 32'h1020, 32'h2600, 8, 0);
    snap(); model_copy(32'h1020, 32'h2600, 8, 1, 1);
    start(32'hE0);
    repeat (80) @(negedge clk);
    wr(8'h00, 32'h4000_0001);
    wait_idle("R9 skip end");
    cmp("R9 next ran", 32'h2600, 2);
    cmp("R9 skipped untouched", 32'h2500, 1);
    rd(8'h00, v); chk("R9 no flag", v & 32'h4, 0);

    // R9 skip with link cleared
    mem[32'h2700 / 4] = 32'h0;
    put_cb(32'hE0, I_SPACE | I_SINC | I_DINC | (32'd3 << 16), 32'h1000, 32'h2500, 16, 32'h100);
    put_cb(32'h100, I_SINC | I_DINC, 32'h1020, 32'h2700, 8, 0);
    start(32'hE0);
    repeat (80) @(negedge clk);
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h4000_0001);
    wait_idle("R9 stop");
    chk("R9 chain cut", mem[32'h2700 / 4], 0);

    // R6 circular chain, then R11 wipe
    put_cb(32'h120, I_SINC | I_DINC | I_IRQ, 32'h1000, 32'h2800, 4, 32'h140);
    put_cb(32'h140, I_SINC | I_DINC | I_IRQ, 32'h1004, 32'h2804, 4, 32'h120);
    start(32'h120);
    repeat (400) @(negedge clk);
    rd(8'h00, v); chk("R6 cyclic running", v & 32'h1, 1);
    chk("R6 cyclic irq", {31'd0, irq}, 1);
    chk("R6 cyclic data", mem[32'h2804 / 4], mem[32'h1004 / 4]);
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, v); chk("R11 cs", v, 0);
    rd(8'h04, v); chk("R11 cba", v, 0);
    rd(8'h0C, v); chk("R11 src", v, 0);
    rd(8'h1C, v); chk("R11 nxt", v, 0);
    chk("R11 irq", {31'd0, irq}, 0);

    // R10 error
    put_cb(32'h160, I_SINC | I_DINC, 32'h8000_0000, 32'h2900, 8, 0);
    start(32'h160); wait_idle("R10 stop");
    rd(8'h00, v); chk("R10 err", v & 32'h101, 32'h100);
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, v); chk("R11 err clr", v, 0);

    // R3 random copies
    for (int i = 0; i < 8; i++) begin
      int n;
      bit si, di;
      logic [31:0] s, d, len;
      n  = 1 + int'($urandom % 8);
      si = 1'($urandom); di = 1'($urandom);
      s  = 32'h1000 + 4 * ($urandom % 32);
      d  = 32'h3000 + 32'h40 * i;
      len = ($urandom % 2) ? 32'(4 * n) : 32'(4 * n - 1);
      put_cb(32'h180, (si ? I_SINC : 0) | (di ? I_DINC : 0), s, d, len, 0);
      snap(); model_copy(s, d, len, si, di);
      start(32'h180); wait_idle("R3 rand end");
      cmp("R3 rand data", d, di ? n : 1);
      rd(8'h0C, v); chk("R3 rand src", v, s + (si ? 32'(4 * n) : 0));
      rd(8'h10, v); chk("R3 rand dst", v, d + (di ? 32'(4 * n) : 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule